// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command interpreter of a NOR flash, modelled synchronously. The host side delivers bus writes as single-cycle strobes carrying an address, a 16-bit data value and a byte/word width select. Recognised sequences always begin with a two-cycle unlock prefix at fixed addresses. The decoder then issues one-cycle start pulses, which carry the latched target address and data, to a separate program/erase engine. It also drives a mode output that tells the read path whether reads return array data, identifier data or operation status.

A busy input from the engine freezes command decoding while an operation runs. Suspend is the one exception: it is accepted during a sector erase. When busy falls, the mode returns to array reads. A fast mode shortens programming to two cycles. Any cycle that breaks a sequence drops the decoder back to array reads.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_o is 0 (array read), fast_o is 0, and start_o, suspend_o and resume_o are 0.
- R2: The unlock prefix is data AAh at key address A, then data 55h at key address B. In word mode (byte_mode=0), only address bits 10:0 are compared: A=555h, B=2AAh. In byte mode (byte_mode=1), bits 11:0 are compared: A=AAAh, B=555h. Higher address bits are don't-care.
- R3: The third cycle must be at key address A. F0h there sets mode_o to 0, and 90h sets mode_o to 1 (identifier).
- R4: After the prefix, A0h at key A and then any write form a program. One cycle after that fourth strobe, start_o pulses with kind_o=1. op_addr_o and op_data_o hold that write's full address and full 16-bit data, and mode_o becomes 2 (status).
- R5: An erase is the prefix, then 80h at key A, then the prefix again. A sixth cycle of 10h at key A starts a chip erase (kind_o=2). A sixth cycle of 30h at any address starts a sector erase (kind_o=3), with op_addr_o set to that address.
- R6: A single write of F0h to any address, outside a sequence, sets mode_o to 0. This also leaves identifier mode.
- R7: A write with the wrong address or data for its position aborts the sequence and sets mode_o to 0. A later command needs a new unlock prefix.
- R8: Only data bits 7:0 are decoded as the command. Bits 15:8 do not change recognition.
- R9: Prefix plus 20h at key A sets fast_o. In fast mode, A0h at any address followed by any write starts a program (kind_o=1). 90h followed by F0h or 00h clears fast_o. Any other cycle in fast mode aborts to mode 0 and keeps fast_o set.
- R10: While busy is high, or an operation has started and busy has not yet fallen, no command starts anything. When busy falls during an operation that is not suspended, mode_o returns to 0.
- R11: During a sector erase, B0h to any address pulses suspend_o and sets mode_o to 3. While suspended, busy falling has no effect, and 30h pulses resume_o and sets mode_o to 2. B0h during a program or chip erase is ignored.
- R12: If busy falls in the same cycle that B0h is written during a sector erase, completion wins: there is no suspend_o pulse and mode_o becomes 0.
- R13: Every output changes exactly one cycle after the strobe or busy edge that causes it. Each pulse lasts one cycle, and at most one of start_o, suspend_o and resume_o is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Single-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address (byte address in byte mode) |
| wr_data | input | DATA_W | Write data; bits 7:0 carry the command |
| byte_mode | input | 1 | 1 selects byte-mode unlock addresses |
| busy | input | 1 | Program/erase engine is running |
| mode_o | output | 2 | 0 array, 1 identifier, 2 status, 3 erase suspended |
| fast_o | output | 1 | Fast-program mode is active |
| start_o | output | 1 | One-cycle operation start pulse |
| kind_o | output | 2 | 1 program, 2 chip erase, 3 sector erase |
| op_addr_o | output | ADDR_W | Latched target address of the last start |
| op_data_o | output | DATA_W | Latched data of the last start |
| suspend_o | output | 1 | One-cycle erase suspend pulse |
| resume_o | output | 1 | One-cycle erase resume pulse |

## Verification
A suspend write and the end of a sector erase can land on the same clock edge, and only one of them can take effect. The bench provokes this by driving busy low and strobing B0h together at one falling edge, so the next rising edge sees both. The result is judged at the ports: no suspend pulse, and mode returns to array read. Separate directed cases cover suspend with busy held high and a busy fall while suspended, to show that each path still works on its own.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam logic [7:0] CODE_UNLOCK_1 = 8'hAA;
   localparam logic [7:0] CODE_UNLOCK_2 = 8'h55;
   localparam logic [7:0] CODE_RESET    = 8'hF0;
   localparam logic [7:0] CODE_IDENT    = 8'h90;
   localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
   localparam logic [7:0] CODE_ERASE    = 8'h80;
   localparam logic [7:0] CODE_CHIP     = 8'h10;
   localparam logic [7:0] CODE_SECTOR   = 8'h30;
   localparam logic [7:0] CODE_FAST     = 8'h20;
   localparam logic [7:0] CODE_SUSPEND  = 8'hB0;
   localparam logic [7:0] CODE_RESUME   = 8'h30;
   localparam logic [7:0] CODE_ALT_EXIT = 8'h00;

   typedef enum logic [1:0] {
      MODE_ARRAY   = 2'd0,
      MODE_IDENT   = 2'd1,
      MODE_STATUS  = 2'd2,
      MODE_SUSPEND = 2'd3
   } fcd_mode_e;

   typedef enum logic [1:0] {
      KIND_NONE   = 2'd0,
      KIND_PROG   = 2'd1,
      KIND_CHIP   = 2'd2,
      KIND_SECTOR = 2'd3
   } fcd_kind_e;

   typedef enum logic [3:0] {
      SEQ_IDLE   = 4'd0,
      SEQ_UNLK1  = 4'd1,
      SEQ_UNLK2  = 4'd2,
      SEQ_PGM    = 4'd3,
      SEQ_ERS0   = 4'd4,
      SEQ_ERS1   = 4'd5,
      SEQ_ERS2   = 4'd6,
      SEQ_FPGM   = 4'd7,
      SEQ_FEXIT  = 4'd8
   } fcd_seq_e;

   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_PROG = 3'd1,
      OP_CHIP = 3'd2,
      OP_SECT = 3'd3,
      OP_HELD = 3'd4
   } fcd_op_e;

   typedef struct packed {
      logic to_array;
      logic to_ident;
      logic do_prog;
      logic do_chip;
      logic do_sect;
   } fcd_event_t;

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
   parameter int              KEY_W        = 11,
   parameter logic [KEY_W-1:0] KEY_A       = 11'h555,
   parameter logic [KEY_W-1:0] KEY_B       = 11'h2AA,
   parameter bit              BYTE_MODE_EN = 1'b1
) (
   input  logic [KEY_W:0] addr,
   input  logic           byte_mode,
   output logic           hit_a,
   output logic           hit_b
);

   localparam logic [KEY_W:0] BYTE_KEY_A = {KEY_A, 1'b0};
   localparam logic [KEY_W:0] BYTE_KEY_B = {KEY_B, 1'b1};

   logic word_a, word_b;
   assign word_a = (addr[KEY_W-1:0] == KEY_A);
   assign word_b = (addr[KEY_W-1:0] == KEY_B);

   generate
      if (BYTE_MODE_EN) begin : g_dual
         logic byte_a, byte_b;
         assign byte_a = (addr == BYTE_KEY_A);
         assign byte_b = (addr == BYTE_KEY_B);
         assign hit_a  = byte_mode ? byte_a : word_a;
         assign hit_b  = byte_mode ? byte_b : word_b;
      end else begin : g_word_only
         logic unused_sel;
         assign unused_sel = byte_mode ^ addr[KEY_W];
         assign hit_a = word_a;
         assign hit_b = word_b;
      end
   endgenerate

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import flash_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic [7:0] cmd,
   input  logic       hit_a,
   input  logic       hit_b,
   output fcd_event_t ev,
   output logic       fast_o
);

   fcd_seq_e state_q, state_d;
   logic     fast_q, fast_d;

   always_comb begin
      state_d = state_q;
      fast_d  = fast_q;
      ev      = '0;
      if (accept) begin
         state_d = SEQ_IDLE;
         unique case (state_q)
            SEQ_IDLE: begin
               if (fast_q) begin
                  if (cmd == CODE_PROGRAM)    state_d = SEQ_FPGM;
                  else if (cmd == CODE_IDENT) state_d = SEQ_FEXIT;
                  else                        ev.to_array = 1'b1;
               end else if (hit_a && cmd == CODE_UNLOCK_1) begin
                  state_d = SEQ_UNLK1;
               end else begin
                  // a lone reset code and any stray write both land here
                  ev.to_array = 1'b1;
               end
            end
            SEQ_UNLK1: begin
               if (hit_b && cmd == CODE_UNLOCK_2) state_d = SEQ_UNLK2;
               else                               ev.to_array = 1'b1;
            end
            SEQ_UNLK2: begin
               if (!hit_a) begin
                  ev.to_array = 1'b1;
               end else begin
                  unique case (cmd)
                     CODE_RESET:   ev.to_array = 1'b1;
                     CODE_IDENT:   ev.to_ident = 1'b1;
                     CODE_PROGRAM: state_d = SEQ_PGM;
                     CODE_ERASE:   state_d = SEQ_ERS0;
                     CODE_FAST: begin
                        fast_d      = 1'b1;
                        ev.to_array = 1'b1;
                     end
                     default:      ev.to_array = 1'b1;
                  endcase
               end
            end
            SEQ_PGM, SEQ_FPGM: ev.do_prog = 1'b1;
            SEQ_ERS0: begin
               if (hit_a && cmd == CODE_UNLOCK_1) state_d = SEQ_ERS1;
               else                               ev.to_array = 1'b1;
            end
            SEQ_ERS1: begin
               if (hit_b && cmd == CODE_UNLOCK_2) state_d = SEQ_ERS2;
               else                               ev.to_array = 1'b1;
            end
            SEQ_ERS2: begin
               if (hit_a && cmd == CODE_CHIP)   ev.do_chip = 1'b1;
               else if (cmd == CODE_SECTOR)     ev.do_sect = 1'b1;
               else                             ev.to_array = 1'b1;
            end
            SEQ_FEXIT: begin
               if (cmd == CODE_RESET || cmd == CODE_ALT_EXIT) fast_d = 1'b0;
               ev.to_array = 1'b1;
            end
            default: ev.to_array = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         fast_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         fast_q  <= fast_d;
      end
   end

   assign fast_o = fast_q;

endmodule

// File: rtl/fcd_op_tracker.sv
module fcd_op_tracker
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [7:0]        cmd,
   input  logic              busy,
   input  fcd_event_t        ev,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              cmd_open,
   output logic [1:0]        mode_o,
   output logic              start_o,
   output logic [1:0]        kind_o,
   output logic [ADDR_W-1:0] op_addr_o,
   output logic [DATA_W-1:0] op_data_o,
   output logic              suspend_o,
   output logic              resume_o
);

   fcd_op_e   op_q;
   fcd_mode_e mode_q;
   fcd_kind_e kind_q;
   logic      busy_q;
   logic      busy_fall;
   logic      launch;
   logic      start_q, suspend_q, resume_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign busy_fall = busy_q & ~busy;
   assign launch    = ev.do_prog | ev.do_chip | ev.do_sect;
   assign cmd_open  = (op_q == OP_IDLE) & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= OP_IDLE;
         mode_q    <= MODE_ARRAY;
         kind_q    <= KIND_NONE;
         busy_q    <= 1'b0;
         start_q   <= 1'b0;
         suspend_q <= 1'b0;
         resume_q  <= 1'b0;
         addr_q    <= '0;
         data_q    <= '0;
      end else begin
         busy_q    <= busy;
         start_q   <= 1'b0;
         suspend_q <= 1'b0;
         resume_q  <= 1'b0;
         unique case (op_q)
            OP_IDLE: begin
               if (launch) begin
                  start_q <= 1'b1;
                  addr_q  <= wr_addr;
                  data_q  <= wr_data;
                  mode_q  <= MODE_STATUS;
                  if (ev.do_prog) begin
                     op_q   <= OP_PROG;
                     kind_q <= KIND_PROG;
                  end else if (ev.do_chip) begin
                     op_q   <= OP_CHIP;
                     kind_q <= KIND_CHIP;
                  end else begin
                     op_q   <= OP_SECT;
                     kind_q <= KIND_SECTOR;
                  end
               end else if (ev.to_ident) begin
                  mode_q <= MODE_IDENT;
               end else if (ev.to_array) begin
                  mode_q <= MODE_ARRAY;
               end
            end
            OP_PROG, OP_CHIP: begin
               if (busy_fall) begin
                  op_q   <= OP_IDLE;
                  mode_q <= MODE_ARRAY;
               end
            end
            OP_SECT: begin
               // completion outranks a suspend landing on the same edge
               if (busy_fall) begin
                  op_q   <= OP_IDLE;
                  mode_q <= MODE_ARRAY;
               end else if (wr_valid && cmd == CODE_SUSPEND) begin
                  op_q      <= OP_HELD;
                  mode_q    <= MODE_SUSPEND;
                  suspend_q <= 1'b1;
               end
            end
            OP_HELD: begin
               if (wr_valid && cmd == CODE_RESUME) begin
                  op_q     <= OP_SECT;
                  mode_q   <= MODE_STATUS;
                  resume_q <= 1'b1;
               end
            end
            default: begin
               op_q   <= OP_IDLE;
               mode_q <= MODE_ARRAY;
            end
         endcase
      end
   end

   assign mode_o    = mode_q;
   assign kind_o    = kind_q;
   assign start_o   = start_q;
   assign suspend_o = suspend_q;
   assign resume_o  = resume_q;
   assign op_addr_o = addr_q;
   assign op_data_o = data_q;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int               ADDR_W       = 21,
   parameter int               DATA_W       = 16,
   parameter int               CMD_W        = 8,
   parameter int               KEY_W        = 11,
   parameter logic [KEY_W-1:0] KEY_A        = 11'h555,
   parameter logic [KEY_W-1:0] KEY_B        = 11'h2AA,
   parameter bit               BYTE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              byte_mode,
   input  logic              busy,
   output logic [1:0]        mode_o,
   output logic              fast_o,
   output logic              start_o,
   output logic [1:0]        kind_o,
   output logic [ADDR_W-1:0] op_addr_o,
   output logic [DATA_W-1:0] op_data_o,
   output logic              suspend_o,
   output logic              resume_o
);

   localparam int MATCH_W = KEY_W + 1;

   generate
      if (CMD_W != 8) begin : g_bad_cmd
         $error("CMD_W must be 8: command codes are byte wide");
      end
      if (DATA_W < CMD_W) begin : g_bad_data
         $error("DATA_W must cover the command byte");
      end
      if (ADDR_W < MATCH_W) begin : g_bad_addr
         $error("ADDR_W must cover the byte-mode key compare");
      end
      if (KEY_A == KEY_B) begin : g_bad_key
         $error("unlock keys must differ");
      end
   endgenerate

   logic [CMD_W-1:0] cmd;
   logic             hit_a, hit_b;
   logic             cmd_open, accept;
   fcd_event_t       ev;

   assign cmd    = wr_data[CMD_W-1:0];
   assign accept = wr_valid & cmd_open;

   fcd_addr_match #(
      .KEY_W       (KEY_W),
      .KEY_A       (KEY_A),
      .KEY_B       (KEY_B),
      .BYTE_MODE_EN(BYTE_MODE_EN)
   ) u_match (
      .addr     (wr_addr[MATCH_W-1:0]),
      .byte_mode(byte_mode),
      .hit_a    (hit_a),
      .hit_b    (hit_b)
   );

   fcd_seq_fsm u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .accept(accept),
      .cmd   (cmd),
      .hit_a (hit_a),
      .hit_b (hit_b),
      .ev    (ev),
      .fast_o(fast_o)
   );

   fcd_op_tracker #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_ops (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .cmd      (cmd),
      .busy     (busy),
      .ev       (ev),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cmd_open (cmd_open),
      .mode_o   (mode_o),
      .start_o  (start_o),
      .kind_o   (kind_o),
      .op_addr_o(op_addr_o),
      .op_data_o(op_data_o),
      .suspend_o(suspend_o),
      .resume_o (resume_o)
   );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_valid,
   input logic       busy,
   input logic [1:0] mode_o,
   input logic       fast_o,
   input logic       start_o,
   input logic       suspend_o,
   input logic       resume_o
);

   assert_one_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_o, suspend_o, resume_o}));

   assert_start_follows_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(wr_valid));

   assert_start_single_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   assert_no_start_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> !$past(busy));

   assert_busy_fall_to_array_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !busy && mode_o == 2'd2) |=> mode_o == 2'd0);

   assert_start_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> mode_o == 2'd2);

   assert_suspend_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_o |-> (mode_o == 2'd3 && $past(wr_valid)));

   assert_resume_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> (mode_o == 2'd2 && $past(mode_o) == 2'd3));

   assert_fast_entry_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fast_o) |-> $past(wr_valid));

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_valid (wr_valid),
   .busy     (busy),
   .mode_o   (mode_o),
   .fast_o   (fast_o),
   .start_o  (start_o),
   .suspend_o(suspend_o),
   .resume_o (resume_o)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [20:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        byte_mode = 1'b0;
   logic        busy = 1'b0;
   logic [1:0]  mode_o;
   logic        fast_o, start_o, suspend_o, resume_o;
   logic [1:0]  kind_o;
   logic [20:0] op_addr_o;
   logic [15:0] op_data_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // reference state, built from the requirements
   int m_seq = 0;
   bit m_fast = 1'b0;
   int m_mode = 0;

   logic [20:0] sa [6];
   logic [15:0] sd [6];
   int          slen;

   always #2.5 clk = ~clk;

   flash_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .byte_mode(byte_mode), .busy(busy),
      .mode_o(mode_o), .fast_o(fast_o), .start_o(start_o), .kind_o(kind_o),
      .op_addr_o(op_addr_o), .op_data_o(op_data_o),
      .suspend_o(suspend_o), .resume_o(resume_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [20:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_addr  = a;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   function automatic logic [20:0] key_a(input bit bm);
      return bm ? 21'h000AAA : 21'h000555;
   endfunction

   function automatic logic [20:0] key_b(input bit bm);
      return bm ? 21'h000555 : 21'h0002AA;
   endfunction

   task automatic unlock(input bit bm);
      wr(key_a(bm), 16'h00AA);
      wr(key_b(bm), 16'h0055);
   endtask

   task automatic engine(input int n);
      @(negedge clk);
      busy = 1'b1;
      repeat (n) @(negedge clk);
      busy = 1'b0;
      @(negedge clk);
   endtask

   task automatic model_step(input logic [20:0] a, input logic [15:0] d, input bit bm,
                             output bit st, output logic [1:0] kd);
      logic [7:0] c;
      bit ha, hb;
      int nx;
      c  = d[7:0];
      ha = bm ? (a[11:0] == 12'hAAA) : (a[10:0] == 11'h555);
      hb = bm ? (a[11:0] == 12'h555) : (a[10:0] == 11'h2AA);
      st = 1'b0;
      kd = 2'd0;
      nx = 0;
      case (m_seq)
         0: begin
            if (m_fast) begin
               if (c == 8'hA0)      nx = 7;
               else if (c == 8'h90) nx = 8;
               else                 m_mode = 0;
            end else if (ha && c == 8'hAA) nx = 1;
            else m_mode = 0;
         end
         1: if (hb && c == 8'h55) nx = 2; else m_mode = 0;
         2: begin
            if (!ha) m_mode = 0;
            else if (c == 8'h90) m_mode = 1;
            else if (c == 8'hA0) nx = 3;
            else if (c == 8'h80) nx = 4;
            else if (c == 8'h20) begin m_fast = 1'b1; m_mode = 0; end
            else m_mode = 0;
         end
         3, 7: begin st = 1'b1; kd = 2'd1; end
         4: if (ha && c == 8'hAA) nx = 5; else m_mode = 0;
         5: if (hb && c == 8'h55) nx = 6; else m_mode = 0;
         6: begin
            if (ha && c == 8'h10)  begin st = 1'b1; kd = 2'd2; end
            else if (c == 8'h30)   begin st = 1'b1; kd = 2'd3; end
            else m_mode = 0;
         end
         8: begin
            if (c == 8'hF0 || c == 8'h00) m_fast = 1'b0;
            m_mode = 0;
         end
         default: m_mode = 0;
      endcase
      m_seq = nx;
      if (st) m_mode = 2;
   endtask

   task automatic put(input int i, input logic [20:0] a, input logic [7:0] code);
      sa[i] = a;
      sd[i] = {8'($urandom), code};
   endtask

   task automatic build(input bit bm, input int pick);
      logic [20:0] hi;
      hi = 21'(($urandom % 512) << 12);
      if (pick <= 5) begin
         put(0, key_a(bm) | hi, 8'hAA);
         put(1, key_b(bm) | hi, 8'h55);
      end
      case (pick)
         0: begin put(2, key_a(bm), 8'hA0); sa[3] = 21'($urandom); sd[3] = 16'($urandom); slen = 4; end
         1, 2: begin
            put(2, key_a(bm), 8'h80);
            put(3, key_a(bm) | hi, 8'hAA);
            put(4, key_b(bm), 8'h55);
            if (pick == 1) put(5, key_a(bm) | hi, 8'h10);
            else           put(5, 21'($urandom), 8'h30);
            slen = 6;
         end
         3: begin put(2, key_a(bm) | hi, 8'h90); slen = 3; end
         4: begin put(2, key_a(bm), 8'hF0); slen = 3; end
         5: begin put(2, key_a(bm), 8'h20); slen = 3; end
         6: begin put(0, 21'($urandom), 8'hF0); slen = 1; end
         7: begin put(0, 21'($urandom), 8'hA0); sa[1] = 21'($urandom); sd[1] = 16'($urandom); slen = 2; end
         default: begin
            put(0, 21'($urandom), 8'h90);
            put(1, 21'($urandom), ($urandom % 2) ? 8'hF0 : 8'h00);
            slen = 2;
         end
      endcase
      for (int i = 0; i < slen; i++) begin
         if ($urandom % 100 < 6) sd[i][7:0] = 8'($urandom);
         if ($urandom % 100 < 6) sa[i] = 21'($urandom);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R13 watchdog expired: actual hung expected done");
      finish_run();
   end

   initial begin
      bit          st;
      logic [1:0]  kd;
      void'($urandom(32'd20240611));

      repeat (4) @(negedge clk);
      chk("R1", "mode in reset", 32'(mode_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "mode", 32'(mode_o), 0);
      chk("R1", "fast", 32'(fast_o), 0);
      chk("R1", "pulses", 32'({start_o, suspend_o, resume_o}), 0);

      // R4 / R2: word-mode program, upper address bits are don't-care
      wr(21'h1F0555, 16'h00AA);
      wr(21'h0A22AA, 16'h0055);
      wr(21'h000555, 16'h00A0);
      chk("R4", "no start on third cycle", 32'(start_o), 0);
      wr(21'h012345, 16'hBEEF);
      chk("R4", "start", 32'(start_o), 1);
      chk("R4", "kind", 32'(kind_o), 1);
      chk("R4", "addr", 32'(op_addr_o), 32'h12345);
      chk("R4", "data", 32'(op_data_o), 32'hBEEF);
      chk("R4", "mode", 32'(mode_o), 2);
      @(negedge clk);
      chk("R13", "start lasts one cycle", 32'(start_o), 0);
      engine(3);
      chk("R10", "mode after busy falls", 32'(mode_o), 0);

      // R5 / R2: byte-mode chip erase
      byte_mode = 1'b1;
      unlock(1'b1);
      wr(21'h000AAA, 16'h0080);
      unlock(1'b1);
      wr(21'h0FFAAA, 16'h0010);
      chk("R5", "chip start", 32'(start_o), 1);
      chk("R5", "chip kind", 32'(kind_o), 2);
      chk("R5", "chip addr", 32'(op_addr_o), 32'h0FFAAA);
      engine(2);
      // R2: word keys do not unlock in byte mode
      unlock(1'b0);
      wr(21'h000555, 16'h0090);
      chk("R2", "word keys rejected in byte mode", 32'(mode_o), 0);
      byte_mode = 1'b0;

      // R3 / R6
      unlock(1'b0);
      wr(21'h000555, 16'h0090);
      chk("R3", "identifier mode", 32'(mode_o), 1);
      wr(21'h013579, 16'h00F0);
      chk("R6", "single reset", 32'(mode_o), 0);
      unlock(1'b0);
      wr(21'h000555, 16'h0090);
      unlock(1'b0);
      chk("R3", "mode held mid-prefix", 32'(mode_o), 1);
      wr(21'h000555, 16'h00F0);
      chk("R3", "prefixed reset", 32'(mode_o), 0);

      // R8: high data byte ignored
      wr(21'h000555, 16'h3CAA);
      wr(21'h0002AA, 16'hFF55);
      wr(21'h000555, 16'h12A0);
      wr(21'h000777, 16'h55AA);
      chk("R8", "start despite high byte", 32'(start_o), 1);
      chk("R8", "data", 32'(op_data_o), 32'h55AA);
      engine(2);

      // R7: aborts
      unlock(1'b0);
      wr(21'h000555, 16'h0090);
      unlock(1'b0);
      wr(21'h000555, 16'h0077);
      chk("R7", "bad code aborts", 32'(mode_o), 0);
      wr(21'h000555, 16'h00A0);
      wr(21'h000100, 16'h1234);
      chk("R7", "no start without prefix", 32'(start_o), 0);
      unlock(1'b0);
      wr(21'h000123, 16'h0090);
      chk("R7", "third cycle off key", 32'(mode_o), 0);

      // R9: fast mode
      unlock(1'b0);
      wr(21'h000555, 16'h0020);
      chk("R9", "fast on", 32'(fast_o), 1);
      wr(21'h01ABCD, 16'h00A0);
      wr(21'h000042, 16'hC0DE);
      chk("R9", "fast start", 32'(start_o), 1);
      chk("R9", "fast kind", 32'(kind_o), 1);
      chk("R9", "fast addr", 32'(op_addr_o), 32'h42);
      chk("R9", "fast data", 32'(op_data_o), 32'hC0DE);
      engine(2);
      wr(21'h000999, 16'h0090);
      wr(21'h000999, 16'h0055);
      chk("R9", "wrong exit keeps fast", 32'(fast_o), 1);
      wr(21'h000999, 16'h0090);
      wr(21'h000999, 16'h0000);
      chk("R9", "exit with 00", 32'(fast_o), 0);

      // R10: busy blocks
      @(negedge clk);
      busy = 1'b1;
      unlock(1'b0);
      wr(21'h000555, 16'h00A0);
      wr(21'h000321, 16'h4321);
      chk("R10", "no start while busy", 32'(start_o), 0);
      @(negedge clk);
      busy = 1'b0;
      @(negedge clk);

      // R11: suspend / resume
      unlock(1'b0);
      wr(21'h000555, 16'h0080);
      unlock(1'b0);
      wr(21'h048000, 16'h0030);
      chk("R5", "sector kind", 32'(kind_o), 3);
      chk("R5", "sector addr", 32'(op_addr_o), 32'h048000);
      @(negedge clk);
      busy = 1'b1;
      wr(21'h000000, 16'h00B0);
      chk("R11", "suspend pulse", 32'(suspend_o), 1);
      chk("R11", "suspend mode", 32'(mode_o), 3);
      busy = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R11", "busy fall ignored while suspended", 32'(mode_o), 3);
      wr(21'h000000, 16'h0030);
      chk("R11", "resume pulse", 32'(resume_o), 1);
      chk("R11", "resume mode", 32'(mode_o), 2);
      engine(2);
      chk("R10", "mode after erase", 32'(mode_o), 0);

      unlock(1'b0);
      wr(21'h000555, 16'h00A0);
      wr(21'h000010, 16'h0001);
      @(negedge clk);
      busy = 1'b1;
      wr(21'h000000, 16'h00B0);
      chk("R11", "suspend ignored in program", 32'(suspend_o), 0);
      chk("R11", "mode stays status", 32'(mode_o), 2);
      engine(1);

      // R12: busy falls on the same edge as a suspend write
      unlock(1'b0);
      wr(21'h000555, 16'h0080);
      unlock(1'b0);
      wr(21'h010000, 16'h0030);
      @(negedge clk);
      busy = 1'b1;
      @(negedge clk);
      @(negedge clk);
      busy = 1'b0;
      wr_valid = 1'b1;
      wr_addr = 21'h0;
      wr_data = 16'h00B0;
      @(negedge clk);
      wr_valid = 1'b0;
      chk("R12", "no suspend pulse", 32'(suspend_o), 0);
      chk("R12", "completion wins", 32'(mode_o), 0);

      // randomized sequences against the reference state
      m_seq = 0; m_fast = 1'b0; m_mode = 0;
      for (int s = 0; s < 400; s++) begin
         bit bm;
         bm = 1'($urandom % 2);
         byte_mode = bm;
         build(bm, m_fast ? 7 + int'($urandom % 2) : int'($urandom % 7));
         for (int i = 0; i < slen; i++) begin
            model_step(sa[i], sd[i], bm, st, kd);
            wr(sa[i], sd[i]);
            chk("R7", "random mode", 32'(mode_o), 32'(m_mode));
            chk("R9", "random fast", 32'(fast_o), 32'(m_fast));
            chk("R13", "random start", 32'(start_o), 32'(st));
            if (st) begin
               chk("R5", "random kind", 32'(kind_o), 32'(kd));
               chk("R4", "random addr", 32'(op_addr_o), 32'(sa[i]));
               chk("R4", "random data", 32'(op_data_o), 32'(sd[i]));
               engine(1 + int'($urandom % 3));
               m_mode = 0;
               chk("R10", "random busy fall", 32'(mode_o), 0);
            end
         end
      end

      finish_run();
   end

endmodule